// File: doc/BRIEF.md
# Two-Page Program Cache Controller

This block keeps two pages of 16-bit instruction words in on-chip memory and fills them from a 24-bit byte-wide external bus. A fill request forms the external start address of the wanted page from a base register and a page-bank register. It checks whether either resident page already holds that address. If neither does, it picks a page to overwrite, honouring a lock bit on each page. It then streams in every word of the page and reports success or failure. A failed fill raises a sticky halt to the core.

The block also owns the core's program counter. Each step pulse from the core advances it. When the counter rolls over while executing from page 0, execution moves to page 1. The page-bank register is reloaded from a holding input, and a fill is started on the spot. A rollover on page 1, or onto a locked page 1, halts the core. The core reads instructions through a combinational read port addressed by page and word index.

Top module: `pcache_ctrl`

## Requirements
- R1: The external start address of a fill is `base_addr + pb * 2 * WORDS`, taken modulo 2^24. The first bus read of a load is at that address.
- R2: If the current page's tag matches, the fill succeeds with no bus read. `busy` is high for exactly 2 cycles, and `cur_page` is unchanged.
- R3: If only the other page's tag matches, the fill succeeds with no bus read in 2 busy cycles, and `cur_page` switches to that page. The two valid tags never hold the same address.
- R4: On a double miss the victim is the other page, unless it is locked (`lock[p]=1`). In that case the victim is the current page. If that page is locked too, the fill fails (`done` with `fill_ok=0`) with no bus read, `halt` rises, and `cur_page` is unchanged. A loaded page is never a locked one.
- R5: A load writes the new tag, makes the victim the current page, and reads 2*WORDS bytes from consecutive addresses. The low byte of each word is read first. `rd_word` then returns `{high, low}` for each index.
- R6: Each word costs a wait of 1+`rom_wait` cycles if its low-byte address is below ROM_END. It costs 1+`ram_wait` cycles if that address is in [RAM_BEG, RAM_END), and 1 cycle otherwise. Two read cycles follow the wait. A loading fill is busy for 2 + Σ(cost+2) cycles.
- R7: A `pc_step` pulse while idle, not halted and without `fill_req` increments `pc` by one. While `halt` is high, `pc_step` leaves `pc` unchanged.
- R8: A rollover of `pc` to 0 while `cur_page`=1 raises `halt`.
- R9: A rollover on page 0 sets `cur_page` to 1. If `lock[1]` is set, `halt` rises and no fill starts.
- R10: Otherwise, a rollover on page 0 loads `pb` from `hold_bank` and runs a fill for that bank under the rules of R2 to R6.
- R11: After reset `busy`, `halt`, `pc`, `pb` and `cur_page` are 0, and both tags are invalid, so the first fill always loads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| base_addr | input | ADDR_W | Base of the program area |
| bank_we | input | 1 | Write strobe for the page-bank register |
| bank_wdata | input | BANK_W | Value written to the page-bank register |
| hold_bank | input | BANK_W | Bank taken over on a page-0 rollover |
| lock | input | 2 | Per-page lock; bit p protects page p |
| rom_wait | input | WAIT_W | Extra wait cycles per word in the ROM region |
| ram_wait | input | WAIT_W | Extra wait cycles per word in the RAM region |
| fill_req | input | 1 | Starts a fill when idle |
| pc_step | input | 1 | Advance the program counter |
| bus_req | output | 1 | External byte read this cycle |
| bus_addr | output | ADDR_W | External byte address |
| bus_rdata | input | 8 | Byte returned in the same cycle |
| rd_page | input | 1 | Instruction read page |
| rd_idx | input | PC_W | Instruction read word index |
| rd_word | output | 16 | Instruction word at rd_page/rd_idx |
| pb | output | BANK_W | Page-bank register |
| pc | output | PC_W | Program counter |
| cur_page | output | 1 | Current execution page |
| busy | output | 1 | Fill in progress |
| done | output | 1 | One-cycle end-of-fill marker |
| fill_ok | output | 1 | Fill outcome, valid with done |
| halt | output | 1 | Sticky core halt |

## Verification
The assertions take for granted that `lock` holds still while a fill is running, that `bus_rdata` is valid in the same cycle as `bus_req`, and that `pc_step` and `fill_req` are never raised together. The bench changes locks, wait values and the base only while `busy` is low. It drives each request as a single-cycle pulse, and its byte memory is a combinational function of the address. Under these conditions the stimulus sweeps banks across the ROM region, the RAM region and the gap between them, including pages that straddle a region edge.

// File: rtl/pcache_pkg.sv
package pcache_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_LOOKUP, S_WAIT, S_LOAD_LO, S_LOAD_HI, S_DONE
  } fill_state_e;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned WORD_W = 2 * BYTE_W;
endpackage

// File: rtl/pcache_lookup.sv
module pcache_lookup #(
  parameter int unsigned ADDR_W = 24
) (
  input  logic [1:0]             vld,
  input  logic [1:0][ADDR_W-1:0] tags,
  input  logic                   cur,
  input  logic [1:0]             lock,
  input  logic [ADDR_W-1:0]      key,
  output logic                   hit_cur,
  output logic                   hit_oth,
  output logic                   victim,
  output logic                   load_ok
);
  logic oth;

  always_comb begin
    oth     = ~cur;
    hit_cur = vld[cur] && (tags[cur] == key);
    hit_oth = vld[oth] && (tags[oth] == key);
    // prefer the other page; fall back to the current one when it is locked
    victim  = lock[oth] ? cur : oth;
    load_ok = ~lock[victim];
  end
endmodule

// File: rtl/pcache_cost.sv
module pcache_cost #(
  parameter int unsigned ADDR_W  = 24,
  parameter int unsigned WAIT_W  = 3,
  parameter int unsigned ROM_END = 'h400000,
  parameter int unsigned RAM_BEG = 'h600000,
  parameter int unsigned RAM_END = 'h700000
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [WAIT_W-1:0] rom_wait,
  input  logic [WAIT_W-1:0] ram_wait,
  output logic [WAIT_W:0]   cost
);
  function automatic logic [WAIT_W:0] word_cost(
    input logic [ADDR_W-1:0] a,
    input logic [WAIT_W-1:0] rw,
    input logic [WAIT_W-1:0] aw
  );
    if (32'(a) < ROM_END)                          return (WAIT_W+1)'(rw) + 1'b1;
    else if (32'(a) >= RAM_BEG && 32'(a) < RAM_END) return (WAIT_W+1)'(aw) + 1'b1;
    else                                           return (WAIT_W+1)'(1);
  endfunction

  assign cost = word_cost(addr, rom_wait, ram_wait);
endmodule

// File: rtl/pcache_wordram.sv
module pcache_wordram #(
  parameter int unsigned WORDS = 256,
  parameter int unsigned PC_W  = $clog2(WORDS)
) (
  input  logic                         clk,
  input  logic                         wr_en,
  input  logic                         wr_page,
  input  logic [PC_W-1:0]              wr_idx,
  input  logic [pcache_pkg::WORD_W-1:0] wr_data,
  input  logic                         rd_page,
  input  logic [PC_W-1:0]              rd_idx,
  output logic [pcache_pkg::WORD_W-1:0] rd_data
);
  logic [1:0][pcache_pkg::WORD_W-1:0] rd_q;

  for (genvar p = 0; p < 2; p++) begin : g_page
    logic [pcache_pkg::WORD_W-1:0] mem [WORDS];
    always_ff @(posedge clk) begin
      if (wr_en && (wr_page == 1'(p))) mem[wr_idx] <= wr_data;
    end
    assign rd_q[p] = mem[rd_idx];
  end

  assign rd_data = rd_q[rd_page];
endmodule

// File: rtl/pcache_ctrl.sv
module pcache_ctrl #(
  parameter int unsigned ADDR_W  = 24,
  parameter int unsigned BANK_W  = 8,
  parameter int unsigned WAIT_W  = 3,
  parameter int unsigned WORDS   = 256,
  parameter int unsigned ROM_END = 'h400000,
  parameter int unsigned RAM_BEG = 'h600000,
  parameter int unsigned RAM_END = 'h700000,
  localparam int unsigned PC_W   = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic              bank_we,
  input  logic [BANK_W-1:0] bank_wdata,
  input  logic [BANK_W-1:0] hold_bank,
  input  logic [1:0]        lock,
  input  logic [WAIT_W-1:0] rom_wait,
  input  logic [WAIT_W-1:0] ram_wait,
  input  logic              fill_req,
  input  logic              pc_step,
  output logic              bus_req,
  output logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_rdata,
  input  logic              rd_page,
  input  logic [PC_W-1:0]   rd_idx,
  output logic [15:0]       rd_word,
  output logic [BANK_W-1:0] pb,
  output logic [PC_W-1:0]   pc,
  output logic              cur_page,
  output logic              busy,
  output logic              done,
  output logic              fill_ok,
  output logic              halt
);
  import pcache_pkg::*;

  localparam int unsigned SHIFT = PC_W + 1;
  localparam logic [PC_W-1:0] LAST = PC_W'(WORDS - 1);

  function automatic logic [ADDR_W-1:0] page_addr(
    input logic [ADDR_W-1:0] b,
    input logic [BANK_W-1:0] k
  );
    return b + (ADDR_W'(k) << SHIFT);
  endfunction

  fill_state_e             state;
  logic [1:0]              vld;
  logic [1:0][ADDR_W-1:0]  tags;
  logic [ADDR_W-1:0]       fill_addr;
  logic [ADDR_W-1:0]       byte_addr;
  logic [PC_W-1:0]         widx;
  logic [WAIT_W:0]         wcnt;
  logic [7:0]              lo_byte;
  logic                    ok_r;

  // named internal events
  logic                    hit_cur, hit_oth, victim, load_ok;
  logic                    step_evt, roll_evt;
  logic [ADDR_W-1:0]       cost_addr;
  logic [WAIT_W:0]         cost;
  logic                    ram_we;

  assign step_evt  = (state == S_IDLE) && !fill_req && pc_step && !halt;
  assign roll_evt  = step_evt && (pc == LAST);
  assign cost_addr = (state == S_LOOKUP) ? fill_addr : byte_addr + 1'b1;
  assign ram_we    = (state == S_LOAD_HI);

  pcache_lookup #(.ADDR_W(ADDR_W)) u_lookup (
    .vld(vld), .tags(tags), .cur(cur_page), .lock(lock), .key(fill_addr),
    .hit_cur(hit_cur), .hit_oth(hit_oth), .victim(victim), .load_ok(load_ok)
  );

  pcache_cost #(
    .ADDR_W(ADDR_W), .WAIT_W(WAIT_W),
    .ROM_END(ROM_END), .RAM_BEG(RAM_BEG), .RAM_END(RAM_END)
  ) u_cost (
    .addr(cost_addr), .rom_wait(rom_wait), .ram_wait(ram_wait), .cost(cost)
  );

  pcache_wordram #(.WORDS(WORDS), .PC_W(PC_W)) u_ram (
    .clk(clk), .wr_en(ram_we), .wr_page(cur_page), .wr_idx(widx),
    .wr_data({bus_rdata, lo_byte}), .rd_page(rd_page), .rd_idx(rd_idx),
    .rd_data(rd_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      vld       <= '0;
      tags      <= '0;
      fill_addr <= '0;
      byte_addr <= '0;
      widx      <= '0;
      wcnt      <= '0;
      lo_byte   <= '0;
      ok_r      <= 1'b0;
      cur_page  <= 1'b0;
      pb        <= '0;
      pc        <= '0;
      halt      <= 1'b0;
    end else begin
      if (bank_we) pb <= bank_wdata;
      unique case (state)
        S_IDLE: begin
          if (fill_req) begin
            fill_addr <= page_addr(base_addr, pb);
            state     <= S_LOOKUP;
          end else if (step_evt) begin
            pc <= pc + 1'b1;
            if (roll_evt) begin
              if (cur_page) begin
                halt <= 1'b1;
              end else begin
                cur_page <= 1'b1;
                if (lock[1]) begin
                  halt <= 1'b1;
                end else begin
                  pb        <= hold_bank;
                  fill_addr <= page_addr(base_addr, hold_bank);
                  state     <= S_LOOKUP;
                end
              end
            end
          end
        end
        S_LOOKUP: begin
          if (hit_cur) begin
            ok_r  <= 1'b1;
            state <= S_DONE;
          end else if (hit_oth) begin
            cur_page <= ~cur_page;
            ok_r     <= 1'b1;
            state    <= S_DONE;
          end else if (load_ok) begin
            cur_page     <= victim;
            tags[victim] <= fill_addr;
            vld[victim]  <= 1'b1;
            byte_addr    <= fill_addr;
            widx         <= '0;
            wcnt         <= cost - 1'b1;
            state        <= S_WAIT;
          end else begin
            ok_r  <= 1'b0;
            halt  <= 1'b1;
            state <= S_DONE;
          end
        end
        S_WAIT: begin
          if (wcnt == '0) state <= S_LOAD_LO;
          else            wcnt  <= wcnt - 1'b1;
        end
        S_LOAD_LO: begin
          lo_byte   <= bus_rdata;
          byte_addr <= byte_addr + 1'b1;
          state     <= S_LOAD_HI;
        end
        S_LOAD_HI: begin
          byte_addr <= byte_addr + 1'b1;
          widx      <= widx + 1'b1;
          if (widx == LAST) begin
            ok_r  <= 1'b1;
            state <= S_DONE;
          end else begin
            wcnt  <= cost - 1'b1;
            state <= S_WAIT;
          end
        end
        S_DONE:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign bus_req  = (state == S_LOAD_LO) || (state == S_LOAD_HI);
  assign bus_addr = byte_addr;
  assign busy     = (state != S_IDLE);
  assign done     = (state == S_DONE);
  assign fill_ok  = done && ok_r;

  AST_HIGH_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_LOAD_LO) |=> bus_req && (bus_addr == $past(bus_addr) + 1'b1)); // R5

  AST_HIT_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_LOOKUP && (hit_cur || hit_oth)) |=> done && fill_ok && !bus_req); // R2

  AST_TAGS_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
    (vld == 2'b11) |-> (tags[0] != tags[1])); // R3

  AST_LOAD_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> !lock[cur_page]); // R4

  AST_FAIL_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fill_ok) |-> halt); // R4

  AST_HALT_FREEZES_PC: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> $stable(pc)); // R7

  AST_PAGE1_ROLL_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    (roll_evt && cur_page) |=> halt && (pc == '0)); // R8

  AST_LOCKED_ROLL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (roll_evt && !cur_page && lock[1]) |=> halt && !busy && cur_page); // R9
endmodule

// File: tb/pcache_ctrl_bench.sv
module pcache_ctrl_bench;
  localparam int WORDS = 16;
  localparam int PC_W  = 4;
  localparam int OC_HIT = 0, OC_LOAD = 1, OC_FAIL = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [23:0] base_addr;
  logic        bank_we;
  logic [7:0]  bank_wdata, hold_bank;
  logic [1:0]  lock;
  logic [2:0]  rom_wait, ram_wait;
  logic        fill_req, pc_step;
  logic        bus_req;
  logic [23:0] bus_addr;
  logic [7:0]  bus_rdata;
  logic        rd_page;
  logic [PC_W-1:0] rd_idx;
  logic [15:0] rd_word;
  logic [7:0]  pb;
  logic [PC_W-1:0] pc;
  logic        cur_page, busy, done, fill_ok, halt;

  always #10 clk = ~clk;

  function automatic logic [7:0] mem_byte(input logic [23:0] a);
    return a[7:0] ^ (a[15:8] * 8'd13) ^ 8'h5A;
  endfunction

  assign bus_rdata = mem_byte(bus_addr);

  pcache_ctrl #(
    .WORDS(WORDS), .ROM_END('h100), .RAM_BEG('h200), .RAM_END('h300)
  ) u_pcache_ctrl (
    .clk(clk), .rst_n(rst_n), .base_addr(base_addr), .bank_we(bank_we),
    .bank_wdata(bank_wdata), .hold_bank(hold_bank), .lock(lock),
    .rom_wait(rom_wait), .ram_wait(ram_wait), .fill_req(fill_req),
    .pc_step(pc_step), .bus_req(bus_req), .bus_addr(bus_addr),
    .bus_rdata(bus_rdata), .rd_page(rd_page), .rd_idx(rd_idx),
    .rd_word(rd_word), .pb(pb), .pc(pc), .cur_page(cur_page), .busy(busy),
    .done(done), .fill_ok(fill_ok), .halt(halt)
  );

  int n_chk = 0, n_err = 0;
  logic        m_vld [2];
  logic [23:0] m_tag [2];
  logic        m_cur, m_halt;

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  function automatic int cost(input logic [23:0] a);
    if (a < 24'h100) return 1 + int'(rom_wait);
    if (a >= 24'h200 && a < 24'h300) return 1 + int'(ram_wait);
    return 1;
  endfunction

  task automatic model_fill(input logic [23:0] a, output int oc);
    logic v;
    if (m_vld[m_cur] && m_tag[m_cur] == a) oc = OC_HIT;
    else if (m_vld[!m_cur] && m_tag[!m_cur] == a) begin
      m_cur = !m_cur; oc = OC_HIT;
    end else begin
      v = !m_cur;
      if (lock[v]) v = m_cur;
      if (lock[v]) begin oc = OC_FAIL; m_halt = 1'b1; end
      else begin m_cur = v; m_vld[v] = 1'b1; m_tag[v] = a; oc = OC_LOAD; end
    end
  endtask

  task automatic watch_fill(input logic [23:0] a, input int oc, input string rq);
    int cyc = 0, nrd = 0, bad = 0, exp_cyc = 2;
    logic seen_done = 1'b0, seen_ok = 1'b0;
    while (busy === 1'b1 && cyc < 5000) begin
      cyc++;
      if (bus_req) begin
        if (bus_addr !== a + 24'(nrd)) bad++;
        nrd++;
      end
      if (done) begin seen_done = 1'b1; seen_ok = fill_ok; end
      @(negedge clk);
    end
    if (oc == OC_LOAD)
      for (int w = 0; w < WORDS; w++) exp_cyc += cost(a + 24'(2*w)) + 2;
    chk({rq, " R6 busy cycles"}, cyc, exp_cyc);
    chk({rq, " bus read count"}, nrd, (oc == OC_LOAD) ? 2*WORDS : 0);
    chk({rq, " R1/R5 byte address sequence"}, bad, 0);
    chk({rq, " done pulse"}, seen_done, 1);
    chk({rq, " fill outcome"}, seen_ok, oc != OC_FAIL);
    chk({rq, " current page"}, cur_page, m_cur);
    chk({rq, " halt"}, halt, m_halt);
    if (oc == OC_LOAD) begin
      bad = 0;
      rd_page = m_cur;
      for (int i = 0; i < WORDS; i++) begin
        rd_idx = PC_W'(i);
        #1;
        if (rd_word !== {mem_byte(a + 24'(2*i+1)), mem_byte(a + 24'(2*i))}) bad++;
      end
      chk({rq, " R5 page contents"}, bad, 0);
    end
  endtask

  task automatic do_fill(input logic [7:0] k, input string rq);
    logic [23:0] a;
    int oc;
    @(negedge clk); bank_we = 1'b1; bank_wdata = k;
    @(negedge clk); bank_we = 1'b0; fill_req = 1'b1;
    a = base_addr + 24'(k) * 24'(2*WORDS);
    model_fill(a, oc);
    @(negedge clk); fill_req = 1'b0;
    watch_fill(a, oc, rq);
    chk({rq, " bank register"}, pb, k);
  endtask

  task automatic step_once();
    @(negedge clk); pc_step = 1'b1;
    @(negedge clk); pc_step = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; base_addr = '0; bank_we = 1'b0; bank_wdata = '0; hold_bank = '0;
    lock = 2'b00; rom_wait = 3'd2; ram_wait = 3'd3; fill_req = 1'b0; pc_step = 1'b0;
    rd_page = 1'b0; rd_idx = '0;
    m_vld[0] = 1'b0; m_vld[1] = 1'b0; m_tag[0] = '0; m_tag[1] = '0;
    m_cur = 1'b0; m_halt = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [23:0] a;
    int oc;
    do_reset();
    chk("R11 busy after reset", busy, 0);
    chk("R11 halt after reset", halt, 0);
    chk("R11 pc after reset", pc, 0);
    chk("R11 pb after reset", pb, 0);
    chk("R11 page after reset", cur_page, 0);
    chk("R11 no bus after reset", bus_req, 0);

    do_fill(8'd0,  "R11 first fill misses");
    do_fill(8'd0,  "R2 current-page hit");
    do_fill(8'd9,  "R4 load into other page");
    do_fill(8'd0,  "R3 other-page hit");
    lock = 2'b01;
    do_fill(8'd20, "R4 other locked, reuse current");
    lock = 2'b11;
    do_fill(8'd5,  "R4 both locked fails");

    do_reset();
    base_addr = 24'h0000F0;
    do_fill(8'd0, "R6 page across ROM edge");
    base_addr = 24'h0001F0;
    do_fill(8'd0, "R6 page across RAM edge");
    base_addr = 24'hFFFFF0;
    do_fill(8'd1, "R1 address wraps at 24 bits");
    base_addr = '0;

    for (int i = 0; i < 36; i++) begin
      lock = 2'(i / 12);
      rom_wait = 3'(i % 8);
      ram_wait = 3'((i * 3) % 8);
      do_fill(8'((i * 7) % 24), "R5 sweep");
    end

    do_reset();
    repeat (5) step_once();
    chk("R7 pc counts steps", pc, 5);
    repeat (10) step_once();
    chk("R7 pc before rollover", pc, 15);
    hold_bank = 8'd4;
    step_once();
    m_cur = 1'b1;
    a = base_addr + 24'(4 * 2 * WORDS);
    model_fill(a, oc);
    watch_fill(a, oc, "R10 rollover fill");
    chk("R10 pb from hold", pb, 4);
    chk("R10 pc wrapped", pc, 0);

    lock = 2'b01;
    hold_bank = 8'd6;
    repeat (16) step_once();
    m_cur = 1'b1;
    a = base_addr + 24'(6 * 2 * WORDS);
    model_fill(a, oc);
    watch_fill(a, oc, "R10 rollover with page 0 locked");
    chk("R10 page after rollover", cur_page, 1);
    repeat (16) step_once();
    chk("R8 halt on page-1 rollover", halt, 1);
    chk("R8 pc wrapped", pc, 0);
    chk("R8 no fill started", busy, 0);
    repeat (3) step_once();
    chk("R7 pc frozen while halted", pc, 0);

    do_reset();
    lock = 2'b10;
    repeat (16) step_once();
    chk("R9 halt when page 1 locked", halt, 1);
    chk("R9 page moved to 1", cur_page, 1);
    chk("R9 no fill", busy, 0);
    chk("R9 pb untouched", pb, 0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule